// File: doc/BRIEF.md
# Scratchpad memory command controller

This block is the byte-level command layer of a small protected memory. A serial slave link in front of it delivers each received byte with a one-cycle strobe and reports a fragment when the master stops part-way through a byte. It also raises a strobe when the bus is reset, and it asks for the next byte to send with a take pulse. The controller decodes five command codes. It holds the two-byte target address and a status byte, stages writes in an 8-byte scratchpad, and commits a whole aligned 8-byte block into storage when the master repeats the address and the status byte.

Storage is a 128-byte data area of four 32-byte pages at addresses 00h–7Fh, an 8-byte secret at 80h–87h and an 8-byte register page at 88h–8Fh. Addresses 90h–97h read as FFh. Only the secret load runs without authorisation. An ordinary copy also needs an external MAC-match input, which stands in for the hash engine. The data area can be locked entirely or for page 0 only, and page 1 can be set so that bits can only be cleared.

Top module: `scratch_cmd_ctrl`

## Requirements
- R1: After reset the controller is idle with `tx_en_o` low and every storage byte reads FFh.
- R2: Command 0Fh takes the address low byte, then the high byte, then data. Data goes into scratchpad slots starting at slot (address low byte mod 8). Status bits 2:0 hold the last slot written. Bytes after slot 7 are ignored.
- R3: Command AAh returns the address low byte, the address high byte, the status byte and the 8 scratchpad slots 0..7, then FFh.
- R4: A fragment received during 0Fh data sets status bit 5. While that bit is set, no copy or secret load is accepted.
- R5: Command 55h with matching address bytes and status byte, valid data and the MAC-match input high writes all 8 scratchpad slots into the aligned block of the target, and sets status bit 7.
- R6: A 55h with a wrong address, a wrong status byte or the MAC-match input low leaves storage and status bit 7 unchanged.
- R7: Command 5Ah with a matching address and status writes the scratchpad into the secret without the MAC-match input and sets status bit 7. Secret bytes always read as FFh.
- R8: Command F0h returns bytes from the start address upward, and the register page is readable. It drives nothing when the start address is 98h or higher.
- R9: With the write-all lock set, copies into 00h–7Fh are refused. With the page-0 lock set, only copies into 00h–1Fh are refused.
- R10: With the page-1 clear-only mode set, a copy into 20h–3Fh stores the old byte AND the new byte.
- R11: A bus reset aborts any command and returns to idle with `tx_en_o` low. Scratchpad contents and flags are kept.
- R12: An unknown command code holds `tx_en_o` low for every later byte until a bus reset.
- R13: Each new 0Fh clears status bits 7 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rst_i | input | 1 | Bus reset strobe from the link |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_frag_i | input | 1 | Incomplete byte received |
| tx_take_i | input | 1 | Link consumed the current output byte |
| tx_en_o | output | 1 | Controller is driving output bytes |
| tx_byte_o | output | 8 | Current output byte |
| mac_ok_i | input | 1 | External authorisation match |
| wp_all_i | input | 1 | Lock the whole data area |
| wp_pg0_i | input | 1 | Lock data page 0 |
| otp_pg1_i | input | 1 | Page 1 clear-only mode |

## Verification
A wrong internal state shows up mostly through the status byte and the read paths. A flag that was not cleared or was set wrongly changes the third byte returned by AAh, and a copy accepted in error changes bytes returned by the next F0h. Both are visible within one command sequence. State-machine errors show up sooner: `tx_en_o` is wrong one cycle after the command byte or the bus reset. The directed tests read storage back after every copy and after every refused copy, so a silent write is caught too.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADR_LO, ST_ADR_HI, ST_WR_DATA,
      ST_ES_IN, ST_RD_SP, ST_RD_MEM, ST_WAIT
   } ctrl_state_t;

   localparam logic [7:0] OP_WR_SP    = 8'h0F;
   localparam logic [7:0] OP_RD_SP    = 8'hAA;
   localparam logic [7:0] OP_COPY     = 8'h55;
   localparam logic [7:0] OP_LOAD_KEY = 8'h5A;
   localparam logic [7:0] OP_RD_MEM   = 8'hF0;
   localparam logic [7:0] FILL_BYTE   = 8'hFF;

   localparam int ST_AUTH_BIT = 7;
   localparam int ST_FRAG_BIT = 5;
endpackage

// File: rtl/scp_scratchpad.sv
module scp_scratchpad #(
   parameter int SP_BYTES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [15:0]           start_ta_i,
   input  logic                  wr_i,
   input  logic [7:0]            wr_data_i,
   input  logic                  frag_i,
   input  logic                  auth_set_i,
   output logic [15:0]           ta_o,
   output logic [7:0]            status_o,
   output logic                  valid_o,
   output logic [SP_BYTES*8-1:0] data_o
);
   import scp_pkg::*;
   localparam int OFF_W = $clog2(SP_BYTES);

   if (OFF_W > 5 || (1 << OFF_W) != SP_BYTES) begin : g_bad_depth
      $error("scratchpad depth must be a power of two of at most 32");
   end

   logic [15:0]           ta_q;
   logic [OFF_W-1:0]      off_q, end_q;
   logic                  full_q, written_q, frag_q, auth_q;
   logic [SP_BYTES*8-1:0] buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ta_q      <= '0;
         off_q     <= '0;
         end_q     <= '0;
         full_q    <= 1'b0;
         written_q <= 1'b0;
         frag_q    <= 1'b0;
         auth_q    <= 1'b0;
         buf_q     <= '1;
      end else if (start_i) begin
         ta_q      <= start_ta_i;
         off_q     <= start_ta_i[OFF_W-1:0];
         end_q     <= start_ta_i[OFF_W-1:0];
         full_q    <= 1'b0;
         written_q <= 1'b0;
         frag_q    <= 1'b0;
         auth_q    <= 1'b0;
      end else begin
         if (wr_i && !full_q) begin
            buf_q[off_q*8 +: 8] <= wr_data_i;
            end_q     <= off_q;
            written_q <= 1'b1;
            if (off_q == OFF_W'(SP_BYTES - 1)) full_q <= 1'b1;
            else                               off_q  <= off_q + 1'b1;
         end
         if (frag_i)     frag_q <= 1'b1;
         if (auth_set_i) auth_q <= 1'b1;
      end
   end

   always_comb begin
      status_o              = '0;
      status_o[OFF_W-1:0]   = end_q;
      status_o[ST_FRAG_BIT] = frag_q;
      status_o[ST_AUTH_BIT] = auth_q;
   end

   assign ta_o    = ta_q;
   assign valid_o = written_q & ~frag_q;
   assign data_o  = buf_q;
endmodule

// File: rtl/scp_mem_array.sv
module scp_mem_array #(
   parameter int DATA_BYTES = 128,
   parameter int BLK_BYTES  = 8,
   parameter int PAGE_BYTES = 32,
   parameter bit EPROM_EMU  = 1'b1,
   localparam int TOTAL     = DATA_BYTES + 2 * BLK_BYTES,
   localparam int NBLK      = TOTAL / BLK_BYTES,
   localparam int BLK_W     = $clog2(NBLK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cp_go_i,
   input  logic [BLK_W-1:0]       cp_blk_i,
   input  logic [BLK_BYTES*8-1:0] cp_data_i,
   input  logic                   wp_all_i,
   input  logic                   wp_pg0_i,
   input  logic                   otp_pg1_i,
   output logic                   cp_ok_o,
   input  logic [7:0]             rd_idx_i,
   output logic [7:0]             rd_data_o
);
   localparam int NBLK_DATA = DATA_BYTES / BLK_BYTES;
   localparam int BPP       = PAGE_BYTES / BLK_BYTES;
   localparam int CELL_W    = $clog2(TOTAL);

   if (DATA_BYTES % PAGE_BYTES != 0 || PAGE_BYTES % BLK_BYTES != 0) begin : g_bad_geom
      $error("data area must hold whole pages of whole blocks");
   end
   if (TOTAL + 2 * BLK_BYTES > 256 || CELL_W > 8) begin : g_bad_span
      $error("address map must fit one address byte");
   end

   logic [7:0] cell_q [TOTAL];
   logic       in_data, in_pg0, in_pg1, blocked, otp_hit;

   assign in_data = cp_blk_i < BLK_W'(NBLK_DATA);
   assign in_pg0  = cp_blk_i < BLK_W'(BPP);
   assign in_pg1  = (cp_blk_i >= BLK_W'(BPP)) && (cp_blk_i < BLK_W'(2 * BPP));
   assign blocked = in_data && (wp_all_i || (wp_pg0_i && in_pg0));
   assign cp_ok_o = cp_go_i && !blocked && (cp_blk_i < BLK_W'(NBLK));

   if (EPROM_EMU) begin : g_otp
      assign otp_hit = otp_pg1_i && in_pg1;
   end else begin : g_no_otp
      logic unused_otp;
      assign unused_otp = otp_pg1_i & in_pg1;
      assign otp_hit    = 1'b0;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < TOTAL; i++) begin
         if (!rst_n) begin
            cell_q[i] <= 8'hFF;
         end else if (cp_ok_o && cp_blk_i == BLK_W'(i / BLK_BYTES)) begin
            cell_q[i] <= otp_hit ? (cell_q[i] & cp_data_i[(i % BLK_BYTES)*8 +: 8])
                                 : cp_data_i[(i % BLK_BYTES)*8 +: 8];
         end
      end
   end

   always_comb begin
      if (rd_idx_i >= 8'(DATA_BYTES) && rd_idx_i < 8'(DATA_BYTES + BLK_BYTES))
         rd_data_o = 8'hFF;
      else if (rd_idx_i < 8'(TOTAL))
         rd_data_o = cell_q[rd_idx_i[CELL_W-1:0]];
      else
         rd_data_o = 8'hFF;
   end
endmodule

// File: rtl/scratch_cmd_ctrl.sv
module scratch_cmd_ctrl #(
   parameter int DATA_BYTES = 128,
   parameter int SP_BYTES   = 8,
   parameter int PAGE_BYTES = 32,
   parameter bit EPROM_EMU  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_byte_i,
   input  logic       rx_frag_i,
   input  logic       tx_take_i,
   output logic       tx_en_o,
   output logic [7:0] tx_byte_o,
   input  logic       mac_ok_i,
   input  logic       wp_all_i,
   input  logic       wp_pg0_i,
   input  logic       otp_pg1_i
);
   import scp_pkg::*;

   localparam int TOTAL       = DATA_BYTES + 2 * SP_BYTES;
   localparam int NBLK        = TOTAL / SP_BYTES;
   localparam int BLK_W       = $clog2(NBLK);
   localparam int OFF_W       = $clog2(SP_BYTES);
   localparam int SECRET_BASE = DATA_BYTES;
   localparam int SECRET_BLK  = DATA_BYTES / SP_BYTES;
   localparam int ADDR_LIMIT  = DATA_BYTES + 3 * SP_BYTES;
   localparam int LAST_IDX    = SP_BYTES + 3;
   localparam int IDX_W       = $clog2(LAST_IDX + 1);

   if (ADDR_LIMIT > 255) begin : g_bad_limit
      $error("address limit must fit one byte");
   end

   ctrl_state_t           state_q;
   logic [7:0]            cmd_q, ta_lo_q, ta_hi_q, ptr_q;
   logic [IDX_W-1:0]      idx_q, dix;
   logic [15:0]           ta_full, sp_ta;
   logic [7:0]            sp_status, mem_rd;
   logic                  sp_valid, sp_start, sp_wr, sp_frag, es_match;
   logic                  cp_go, cp_ok, addr_ok, is_load;
   logic [BLK_W-1:0]      cp_blk;
   logic [SP_BYTES*8-1:0] sp_data;
   logic                  live_rx;

   assign live_rx  = rx_valid_i && !bus_rst_i;
   assign ta_full  = {ta_hi_q, ta_lo_q};
   assign is_load  = cmd_q == OP_LOAD_KEY;
   assign addr_ok  = ta_full < 16'(TOTAL);
   assign sp_start = state_q == ST_ADR_HI && live_rx && cmd_q == OP_WR_SP;
   assign sp_wr    = state_q == ST_WR_DATA && live_rx;
   assign sp_frag  = state_q == ST_WR_DATA && rx_frag_i;
   assign es_match = ta_full == sp_ta && rx_byte_i == sp_status && sp_valid;
   assign cp_go    = state_q == ST_ES_IN && live_rx && es_match &&
                     (is_load || (mac_ok_i && addr_ok));
   assign cp_blk   = is_load ? BLK_W'(SECRET_BLK) : BLK_W'(ta_full >> OFF_W);

   scp_scratchpad #(.SP_BYTES(SP_BYTES)) sp_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(sp_start), .start_ta_i({rx_byte_i, ta_lo_q}),
      .wr_i(sp_wr), .wr_data_i(rx_byte_i), .frag_i(sp_frag),
      .auth_set_i(cp_ok),
      .ta_o(sp_ta), .status_o(sp_status), .valid_o(sp_valid), .data_o(sp_data)
   );

   scp_mem_array #(
      .DATA_BYTES(DATA_BYTES), .BLK_BYTES(SP_BYTES),
      .PAGE_BYTES(PAGE_BYTES), .EPROM_EMU(EPROM_EMU)
   ) mem_i (
      .clk(clk), .rst_n(rst_n),
      .cp_go_i(cp_go), .cp_blk_i(cp_blk), .cp_data_i(sp_data),
      .wp_all_i(wp_all_i), .wp_pg0_i(wp_pg0_i), .otp_pg1_i(otp_pg1_i),
      .cp_ok_o(cp_ok), .rd_idx_i(ptr_q), .rd_data_o(mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         ta_lo_q <= '0;
         ta_hi_q <= '0;
         idx_q   <= '0;
         ptr_q   <= '0;
      end else if (bus_rst_i) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (rx_valid_i) begin
               cmd_q <= rx_byte_i;
               case (rx_byte_i)
                  OP_WR_SP, OP_COPY, OP_LOAD_KEY, OP_RD_MEM: state_q <= ST_ADR_LO;
                  OP_RD_SP: begin
                     idx_q   <= '0;
                     state_q <= ST_RD_SP;
                  end
                  default: state_q <= ST_WAIT;
               endcase
            end
            ST_ADR_LO: if (rx_valid_i) begin
               ta_lo_q <= rx_byte_i;
               state_q <= ST_ADR_HI;
            end
            ST_ADR_HI: if (rx_valid_i) begin
               ta_hi_q <= rx_byte_i;
               if (cmd_q == OP_WR_SP)
                  state_q <= ST_WR_DATA;
               else if (cmd_q == OP_RD_MEM) begin
                  if ({rx_byte_i, ta_lo_q} < 16'(ADDR_LIMIT)) begin
                     ptr_q   <= ta_lo_q;
                     state_q <= ST_RD_MEM;
                  end else begin
                     state_q <= ST_WAIT;
                  end
               end else
                  state_q <= ST_ES_IN;
            end
            ST_ES_IN: if (rx_valid_i) state_q <= ST_WAIT;
            ST_RD_SP: if (tx_take_i && idx_q != IDX_W'(LAST_IDX)) idx_q <= idx_q + 1'b1;
            ST_RD_MEM: if (tx_take_i && ptr_q != 8'(ADDR_LIMIT)) ptr_q <= ptr_q + 1'b1;
            default: state_q <= state_q;
         endcase
      end
   end

   assign dix     = idx_q - IDX_W'(3);
   assign tx_en_o = state_q == ST_RD_SP || state_q == ST_RD_MEM;

   always_comb begin
      tx_byte_o = FILL_BYTE;
      if (state_q == ST_RD_MEM) begin
         tx_byte_o = mem_rd;
      end else if (state_q == ST_RD_SP) begin
         if (idx_q == IDX_W'(0))           tx_byte_o = sp_ta[7:0];
         else if (idx_q == IDX_W'(1))      tx_byte_o = sp_ta[15:8];
         else if (idx_q == IDX_W'(2))      tx_byte_o = sp_status;
         else if (idx_q < IDX_W'(LAST_IDX)) tx_byte_o = sp_data[dix[OFF_W-1:0]*8 +: 8];
      end
   end
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
   parameter int SECRET_BASE = 128,
   parameter int SP_BYTES    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_rst,
   input logic                 rx_valid,
   input logic [7:0]           rx_byte,
   input logic                 tx_en,
   input logic [7:0]           tx_byte,
   input scp_pkg::ctrl_state_t state,
   input logic [7:0]           mem_ptr,
   input logic [7:0]           sp_status,
   input logic                 sp_start,
   input logic                 mac_ok,
   input logic [7:0]           cmd
);
   import scp_pkg::*;
   logic known_op;
   assign known_op = rx_byte inside {OP_WR_SP, OP_RD_SP, OP_COPY, OP_LOAD_KEY, OP_RD_MEM};

   AST_RST_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !tx_en); // R11
   AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && rx_valid && !bus_rst && !known_op) |=> !tx_en); // R12
   AST_SECRET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_MEM && mem_ptr >= 8'(SECRET_BASE) &&
       mem_ptr < 8'(SECRET_BASE + SP_BYTES)) |-> tx_byte == 8'hFF); // R7
   AST_AUTH_NEEDS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sp_status[ST_AUTH_BIT]) |-> ($past(mac_ok) || $past(cmd) == OP_LOAD_KEY)); // R5
   AST_AUTH_NO_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sp_status[ST_AUTH_BIT]) |-> !sp_status[ST_FRAG_BIT]); // R4
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sp_start |=> (!sp_status[ST_AUTH_BIT] && !sp_status[ST_FRAG_BIT])); // R13
endmodule

bind scratch_cmd_ctrl scp_checker #(.SECRET_BASE(SECRET_BASE), .SP_BYTES(SP_BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst_i), .rx_valid(rx_valid_i),
   .rx_byte(rx_byte_i), .tx_en(tx_en_o), .tx_byte(tx_byte_o), .state(state_q),
   .mem_ptr(ptr_q), .sp_status(sp_status), .sp_start(sp_start),
   .mac_ok(mac_ok_i), .cmd(cmd_q)
);

// File: tb/scratch_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module scratch_cmd_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0, rx_valid = 1'b0, rx_frag = 1'b0, tx_take = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_en;
   logic [7:0] tx_byte;
   logic       mac_ok = 1'b0, wp_all = 1'b0, wp_pg0 = 1'b0, otp_pg1 = 1'b0;
   int         n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   scratch_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .rx_valid_i(rx_valid),
      .rx_byte_i(rx_byte), .rx_frag_i(rx_frag), .tx_take_i(tx_take),
      .tx_en_o(tx_en), .tx_byte_o(tx_byte), .mac_ok_i(mac_ok),
      .wp_all_i(wp_all), .wp_pg0_i(wp_pg0), .otp_pg1_i(otp_pg1)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic brst();
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic take();
      tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic wr_sp(input logic [7:0] lo, input logic [7:0] first, input int n);
      brst();
      send(8'h0F); send(lo); send(8'h00);
      for (int i = 0; i < n; i++) send(first + 8'(i));
   endtask

   task automatic copy(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] es,
                       input logic mac);
      brst();
      mac_ok = mac;
      send(op); send(lo); send(8'h00); send(es);
      mac_ok = 1'b0;
   endtask

   task automatic stat_chk(input string req, input logic [7:0] exp);
      brst();
      send(8'hAA); take(); take();
      chk(req, tx_byte, exp);
   endtask

   task automatic mem_chk(input string req, input logic [7:0] addr, input logic [7:0] exp);
      brst();
      send(8'hF0); send(addr); send(8'h00);
      chk(req, {7'd0, tx_en}, 8'd1);
      chk(req, tx_byte, exp);
   endtask

   task automatic t_reset();
      chk("R1 idle tx_en", {7'd0, tx_en}, 8'd0);
      mem_chk("R1 data erased", 8'h00, 8'hFF);
      mem_chk("R1 reg erased", 8'h8F, 8'hFF);
   endtask

   task automatic t_write_read();
      wr_sp(8'h03, 8'hA1, 6);
      brst();
      send(8'hAA);
      chk("R3 ta lo", tx_byte, 8'h03); take();
      chk("R3 ta hi", tx_byte, 8'h00); take();
      chk("R2 status end=7", tx_byte, 8'h07); take();
      for (int i = 0; i < 8; i++) begin
         chk(i < 3 ? "R2 untouched slot" : "R2 data slot", tx_byte,
             i < 3 ? 8'hFF : 8'hA1 + 8'(i - 3));
         take();
      end
      chk("R3 trailing fill", tx_byte, 8'hFF);
   endtask

   task automatic t_copy_ok();
      wr_sp(8'h10, 8'h10, 8);
      copy(8'h55, 8'h10, 8'h07, 1'b1);
      stat_chk("R5 auth bit", 8'h87);
      mem_chk("R5 below block", 8'h0F, 8'hFF);
      brst();
      send(8'hF0); send(8'h10); send(8'h00);
      for (int i = 0; i < 9; i++) begin
         chk("R5 block bytes", tx_byte, i < 8 ? 8'h10 + 8'(i) : 8'hFF);
         take();
      end
   endtask

   task automatic t_copy_bad();
      wr_sp(8'h20, 8'h30, 5);
      stat_chk("R13 auth cleared", 8'h04);
      copy(8'h55, 8'h20, 8'h05, 1'b1);
      copy(8'h55, 8'h21, 8'h04, 1'b1);
      copy(8'h55, 8'h20, 8'h04, 1'b0);
      stat_chk("R6 no auth", 8'h04);
      mem_chk("R6 storage kept", 8'h20, 8'hFF);
   endtask

   task automatic t_partial();
      wr_sp(8'h28, 8'h50, 2);
      @(negedge clk); rx_frag = 1'b1;
      @(negedge clk); rx_frag = 1'b0;
      stat_chk("R4 frag flag", 8'h21);
      copy(8'h55, 8'h28, 8'h21, 1'b1);
      stat_chk("R4 still refused", 8'h21);
      mem_chk("R4 storage kept", 8'h29, 8'hFF);
   endtask

   task automatic t_secret();
      wr_sp(8'h80, 8'hC0, 8);
      stat_chk("R13 frag cleared", 8'h07);
      copy(8'h5A, 8'h80, 8'h07, 1'b0);
      stat_chk("R7 load accepted", 8'h87);
      mem_chk("R7 secret hidden", 8'h80, 8'hFF);
      mem_chk("R7 secret hidden top", 8'h87, 8'hFF);
   endtask

   task automatic t_readmem();
      wr_sp(8'h88, 8'h90, 8);
      copy(8'h55, 8'h88, 8'h07, 1'b1);
      brst();
      send(8'hF0); send(8'h8E); send(8'h00);
      chk("R8 reg 8E", tx_byte, 8'h96); take();
      chk("R8 reg 8F", tx_byte, 8'h97); take();
      chk("R8 above reg", tx_byte, 8'hFF);
      brst();
      send(8'hF0); send(8'h98); send(8'h00);
      chk("R8 out of range", {7'd0, tx_en}, 8'd0);
      brst();
      send(8'hF0); send(8'h00); send(8'h01);
      chk("R8 high byte range", {7'd0, tx_en}, 8'd0);
   endtask

   task automatic t_protect();
      wp_all = 1'b1;
      wr_sp(8'h40, 8'h40, 8);
      copy(8'h55, 8'h40, 8'h07, 1'b1);
      stat_chk("R9 lock all refused", 8'h07);
      mem_chk("R9 lock all storage", 8'h40, 8'hFF);
      wp_all = 1'b0; wp_pg0 = 1'b1;
      wr_sp(8'h08, 8'h60, 8);
      copy(8'h55, 8'h08, 8'h07, 1'b1);
      mem_chk("R9 page0 refused", 8'h08, 8'hFF);
      wr_sp(8'h48, 8'h70, 8);
      copy(8'h55, 8'h48, 8'h07, 1'b1);
      mem_chk("R9 page2 allowed", 8'h48, 8'h70);
      wp_pg0 = 1'b0;
   endtask

   task automatic t_eprom();
      otp_pg1 = 1'b1;
      wr_sp(8'h30, 8'hF0, 8);
      copy(8'h55, 8'h30, 8'h07, 1'b1);
      mem_chk("R10 first copy", 8'h30, 8'hF0);
      wr_sp(8'h30, 8'h3C, 8);
      copy(8'h55, 8'h30, 8'h07, 1'b1);
      mem_chk("R10 and low", 8'h30, 8'hF0 & 8'h3C);
      mem_chk("R10 and high", 8'h37, 8'hF7 & 8'h43);
      otp_pg1 = 1'b0;
   endtask

   task automatic t_abort();
      wr_sp(8'h50, 8'h11, 2);
      brst();
      chk("R11 idle after reset", {7'd0, tx_en}, 8'd0);
      send(8'hAA);
      chk("R11 ta kept", tx_byte, 8'h50); take(); take();
      chk("R11 status kept", tx_byte, 8'h01); take();
      chk("R11 slot0 kept", tx_byte, 8'h11);
      brst();
      chk("R11 read aborted", {7'd0, tx_en}, 8'd0);
   endtask

   task automatic t_unknown();
      brst();
      send(8'h3C);
      chk("R12 silent", {7'd0, tx_en}, 8'd0);
      send(8'hAA);
      chk("R12 still silent", {7'd0, tx_en}, 8'd0);
      brst();
      send(8'hAA);
      chk("R12 recovers", {7'd0, tx_en}, 8'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_copy_ok();
      t_copy_bad();
      t_partial();
      t_secret();
      t_readmem();
      t_protect();
      t_eprom();
      t_abort();
      t_unknown();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule